// File: doc/BRIEF.md
# Programmable Chip Select Decoder

The block watches a processor-side bus and produces two independent active-low chip-select pins. Each bus access carries an address, a flag that selects the I/O space or the memory space, a read strobe and a write strobe. Each channel holds a base address, an address mask, a space choice and a direction code. The channel pulls its pin low while the current access falls inside its address window, targets the chosen space and has a permitted direction.

Each pin can also be handed over to software as a general-purpose I/O. In that mode the channel drives a fixed level under an output-enable bit, and the decode result no longer reaches the pin. The pin level is captured every cycle so it can be read as an input.

Setup goes through a plain single-cycle register write port. The decode path is purely combinational from the bus inputs, so no handshake is involved anywhere. The configuration port has no back-pressure: a write is taken in the cycle its enable is high.

Top module: `csel_decoder`

## Requirements
- R1: There are exactly two channels, and each has its own registers. `cfg_addr[2]` picks the channel. `cfg_addr[1:0]` picks the register: 0 = base, 1 = mask, 2 = control. A write with `cfg_we` high takes effect at the next rising clock edge and touches no other register.
- R2: An access is inside a channel's window when (`bus_addr` AND mask) equals (base AND mask). A mask bit of 0 means that address bit is ignored.
- R3: Control bit 2 selects the space. With 1 the channel decodes only accesses with `bus_io`=1 (I/O space). With 0 it decodes only accesses with `bus_io`=0 (memory space).
- R4: Control bits [1:0] set the direction. 00 disables the channel, 01 passes reads (`bus_rd`), 10 passes writes (`bus_wr`) and 11 passes either.
- R5: In chip-select mode the pin value is low exactly when R2, R3 and R4 all hold. Otherwise it is high, which includes every cycle with no strobe. The pin responds combinationally to the bus inputs.
- R6: When control bit 3 is 1 the pin is a general-purpose I/O. `pin_oe` follows control bit 4, `pin_out` follows control bit 5, and the bus has no effect on either.
- R7: After reset, base and mask are 0 and control is 0b001000 for both channels. That value means general-purpose I/O mode, output disabled and direction 00, so both pins are undriven inputs (`pin_oe`=0).
- R8: In chip-select mode (control bit 3 = 0) the pin is always driven (`pin_oe`=1).
- R9: `gpio_in` holds the value `pin_in` had at the previous rising clock edge.
- R10: A write to register index 3 of either channel changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Bus address |
| bus_io | input | 1 | 1 = I/O space access, 0 = memory space access |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Channel (bit 2) and register index (bits 1:0) |
| cfg_wdata | input | AW | Configuration write data (control uses bits 5:0) |
| pin_out | output | 2 | Pin level per channel (active-low select in chip-select mode) |
| pin_oe | output | 2 | Pin output enable per channel |
| pin_in | input | 2 | Level observed on each pin |
| gpio_in | output | 2 | Registered copy of pin_in |

## Verification
The hardest condition to reach from the ports is the exact border of a window under a sparse mask, in one space and one direction, while the other channel sits on an overlapping window with a different qualifier. Both pins must then be correct at the same instant. The bench builds the block with an 8-bit address. For several contrasting configurations it sweeps every address against both spaces and all four strobe combinations, and it compares both pins with an arithmetic model after every input change. The configurations cover overlapping windows, all-pass masks, every direction code, and channels held in general-purpose mode with matching windows.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int CTRL_W = 6;

  typedef struct packed {
    logic       gpio_dout;
    logic       gpio_oe;
    logic       gpio_mode;
    logic       io_space;
    logic [1:0] dir;
  } ch_ctrl_t;

  localparam logic [1:0] IDX_BASE = 2'd0;
  localparam logic [1:0] IDX_MASK = 2'd1;
  localparam logic [1:0] IDX_CTRL = 2'd2;

  localparam ch_ctrl_t CTRL_RESET = '{gpio_dout: 1'b0, gpio_oe: 1'b0,
                                      gpio_mode: 1'b1, io_space: 1'b0,
                                      dir: 2'b00};
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int AW  = 16,
  parameter int NCH = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(NCH)+1:0]        addr,
  input  logic [AW-1:0]                 wdata,
  output logic [NCH-1:0][AW-1:0]        base_q,
  output logic [NCH-1:0][AW-1:0]        mask_q,
  output ch_ctrl_t [NCH-1:0]            ctrl_q
);
  localparam int CHW = $clog2(NCH);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = we && (addr[CHW+1:2] == CHW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[c] <= '0;
        mask_q[c] <= '0;
        ctrl_q[c] <= CTRL_RESET;
      end else if (sel) begin
        case (addr[1:0])
          IDX_BASE: base_q[c] <= wdata;
          IDX_MASK: mask_q[c] <= wdata;
          IDX_CTRL: ctrl_q[c] <= ch_ctrl_t'(wdata[CTRL_W-1:0]);
          default:  ;
        endcase
      end
    end

    // R1: a base write lands in the addressed channel on the next edge
    a_r1_base_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr[CHW+1:2] == CHW'(c) && addr[1:0] == IDX_BASE)
        |=> base_q[c] == $past(wdata));

    // R1: a write to the other channel leaves this one untouched
    a_r1_other_ch_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr[CHW+1:2] != CHW'(c))
        |=> $stable(base_q[c]) && $stable(mask_q[c]) && $stable(ctrl_q[c]));
  end

  // R10: index 3 is a hole in the map
  a_r10_hole_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[1:0] == 2'd3)
      |=> $stable(base_q) && $stable(mask_q) && $stable(ctrl_q));
endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          io,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  ch_ctrl_t      ctrl,
  output logic          hit
);
  logic in_window;
  logic space_ok;
  logic dir_ok;

  assign in_window = ((addr ^ base) & mask) == '0;
  assign space_ok  = (io == ctrl.io_space);
  assign dir_ok    = (rd & ctrl.dir[0]) | (wr & ctrl.dir[1]);
  assign hit       = in_window & space_ok & dir_ok;

  // R5: no strobe, no select
  a_r5_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !wr) |-> !hit);

  // R4: code 00 disables the channel
  a_r4_dir_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.dir == 2'b00) |-> !hit);

  // R3: a select only ever happens in the chosen space
  a_r3_space: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (io == ctrl.io_space));

  // R2: a select never happens on an address outside the window
  a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((addr & mask) == (base & mask)));
endmodule

// File: rtl/csel_pin.sv
module csel_pin
  import csel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ch_ctrl_t ctrl,
  input  logic     hit,
  input  logic     pin_in,
  output logic     pin_out,
  output logic     pin_oe,
  output logic     gpio_in
);
  always_comb begin
    if (ctrl.gpio_mode) begin
      pin_oe  = ctrl.gpio_oe;
      pin_out = ctrl.gpio_dout;
    end else begin
      pin_oe  = 1'b1;
      pin_out = ~hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gpio_in <= 1'b0;
    else        gpio_in <= pin_in;
  end

  // R8: chip-select mode always drives
  a_r8_cs_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.gpio_mode |-> pin_oe);

  // R6: in GPIO mode the pin moves only with its control register
  a_r6_gpio_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.gpio_mode && $past(ctrl.gpio_mode) && $stable(ctrl))
      |-> $stable(pin_out) && $stable(pin_oe));

  // R9: input capture is one edge late
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gpio_in == $past(pin_in));
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_io,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [1:0]    pin_out,
  output logic [1:0]    pin_oe,
  input  logic [1:0]    pin_in,
  output logic [1:0]    gpio_in
);
  localparam int NCH = 2;

  logic [NCH-1:0][AW-1:0] base_q;
  logic [NCH-1:0][AW-1:0] mask_q;
  ch_ctrl_t [NCH-1:0]     ctrl_q;
  logic [NCH-1:0]         hit;

  csel_regs #(.AW(AW), .NCH(NCH)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .base_q (base_q),
    .mask_q (mask_q),
    .ctrl_q (ctrl_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    csel_match #(.AW(AW)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .io    (bus_io),
      .rd    (bus_rd),
      .wr    (bus_wr),
      .base  (base_q[c]),
      .mask  (mask_q[c]),
      .ctrl  (ctrl_q[c]),
      .hit   (hit[c])
    );

    csel_pin u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl    (ctrl_q[c]),
      .hit     (hit[c]),
      .pin_in  (pin_in[c]),
      .pin_out (pin_out[c]),
      .pin_oe  (pin_oe[c]),
      .gpio_in (gpio_in[c])
    );

    // R5: a driven select pin with no strobe sits high
    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[c].gpio_mode && !bus_rd && !bus_wr) |-> pin_out[c]);
  end
endmodule

// File: tb/test_csel_decoder.sv
module test_csel_decoder;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_io = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [1:0]    pin_out, pin_oe, gpio_in;
  logic [1:0]    pin_in = '0;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] m_base [2];
  logic [AW-1:0] m_mask [2];
  logic [5:0]    m_ctrl [2];

  always #2 clk = ~clk;

  csel_decoder #(.AW(AW)) i_csel_decoder (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_io(bus_io),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_in(pin_in), .gpio_in(gpio_in)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] ctl(input bit gm, input bit oe, input bit dout,
                                     input bit io, input bit [1:0] dir);
    return {dout, oe, gm, io, dir};
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_base[c] = '0; m_mask[c] = '0; m_ctrl[c] = 6'b001000;
    end
  endtask

  task automatic wr_reg(input int c, input int idx, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {c[0], idx[1:0]}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx == 0) m_base[c] = d;
    else if (idx == 1) m_mask[c] = d;
    else if (idx == 2) m_ctrl[c] = d[5:0];
  endtask

  function automatic logic [1:0] exp_pin(input int c, input logic [AW-1:0] a,
                                         input bit io, input bit rd, input bit wr);
    logic [5:0] k;
    bit hitv;
    k = m_ctrl[c];
    if (k[3]) return {k[4], k[5]};
    hitv = ((a & m_mask[c]) == (m_base[c] & m_mask[c])) && (io == k[2]) &&
           ((rd && k[0]) || (wr && k[1]));
    return {1'b1, !hitv};
  endfunction

  task automatic sweep(input string tag);
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 8; s++) begin
        bus_addr = a[AW-1:0]; bus_io = s[2]; bus_rd = s[0]; bus_wr = s[1];
        #1;
        chk({pin_oe[1], pin_out[1], pin_oe[0], pin_out[0]},
            {exp_pin(1, a[AW-1:0], s[2], s[0], s[1]),
             exp_pin(0, a[AW-1:0], s[2], s[0], s[1])}, tag);
      end
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    #9 rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state, both pins undriven inputs
    chk({2'b00, pin_oe}, 4'b0000, "R7 reset pin_oe");
    sweep("R7 reset sweep");

    // R1 R2 R3 R4 R5 R8: overlapping windows, different qualifiers
    wr_reg(0, 0, 8'h40); wr_reg(0, 1, 8'hF0); wr_reg(0, 2, ctl(0, 0, 0, 0, 2'b11));
    wr_reg(1, 0, 8'h45); wr_reg(1, 1, 8'h0F); wr_reg(1, 2, ctl(0, 0, 0, 1, 2'b01));
    sweep("R2 R3 R4 R5 R8 sweep A");

    // R4: writes only / disabled, R2 sparse mask
    wr_reg(0, 1, 8'hA5); wr_reg(0, 0, 8'h21); wr_reg(0, 2, ctl(0, 0, 0, 1, 2'b10));
    wr_reg(1, 2, ctl(0, 0, 0, 1, 2'b00));
    sweep("R4 R2 sweep B");

    // R2: all-pass mask, R1 channel independence
    wr_reg(1, 1, 8'h00); wr_reg(1, 2, ctl(0, 0, 0, 0, 2'b10));
    sweep("R1 R2 sweep C");

    // R6: GPIO mode with windows that would match
    wr_reg(0, 1, 8'h00); wr_reg(0, 2, ctl(1, 1, 1, 0, 2'b11));
    wr_reg(1, 2, ctl(1, 1, 0, 0, 2'b11));
    sweep("R6 gpio sweep");
    wr_reg(1, 2, ctl(1, 0, 1, 1, 2'b11));
    sweep("R6 gpio oe off sweep");

    // R10: index 3 writes are holes; model unchanged
    wr_reg(0, 3, 8'hFF); wr_reg(1, 3, 8'h00);
    wr_reg(0, 2, ctl(0, 0, 0, 0, 2'b01));
    sweep("R10 hole write sweep");

    // R9: input capture one edge late
    for (int v = 0; v < 4; v++) begin
      @(negedge clk); pin_in = v[1:0];
      @(negedge clk);
      chk({2'b00, gpio_in}, {2'b00, v[1:0]}, "R9 gpio_in capture");
    end

    // R7: reset again restores defaults
    @(negedge clk); rst_n = 1'b0; model_reset();
    #1 chk({2'b00, gpio_in}, 4'b0000, "R7 gpio_in reset");
    @(negedge clk); rst_n = 1'b1;
    sweep("R7 second reset sweep");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule